// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one 32-bit integer by another over many clock cycles, one quotient bit per cycle, with the restoring shift-and-subtract method. A caller presents a dividend, a divisor and a mode bit, then pulses `start`. The block reports progress on `busy`. It then raises `done` for one cycle, with the quotient on `quo_lo` and the remainder on `rem_hi`. Both result words hold their values until the next operation completes.

A single wide shift register holds the partial remainder in its upper part. The quotient bits collect in its lower part as the dividend bits shift out. The divisor stays in a fixed register and feeds a subtractor that sees only the upper part. The register shifts once more than the remainder needs, so the remainder is shifted right by one bit at the end. In signed mode the operands are first reduced to magnitudes. The two results are then negated according to the operand signs. A zero divisor does not stop the operation; it raises a flag alongside `done` and gives fixed results.

Top module: `seq_divider`

## Requirements
- R1: While `rst_n` is low, and directly after it is released, `busy`, `done` and `zero_div` are 0 and `quo_lo` and `rem_hi` are all zeros. Asserting reset in the middle of an operation stops it at once.
- R2: A rising clock edge that sees `start` high while `busy` is low accepts the operands, and `busy` is 1 after that edge. Counting that edge as the first, `done` is 1 after the 34th rising edge, for exactly one cycle.
- R3: With `signed_mode` = 0, both operands are unsigned. `quo_lo` equals floor(dividend / divisor) and `rem_hi` equals dividend mod divisor.
- R4: With `signed_mode` = 1, both operands are two's complement. The quotient is rounded toward zero, so it is negative exactly when the operand signs differ and it is not zero.
- R5: With `signed_mode` = 1, the remainder is zero or has the sign of the dividend, whatever the sign of the divisor, and dividend = quotient × divisor + remainder.
- R6: A divisor of zero, in either mode, gives `zero_div` = 1 in the same cycle as `done`, `quo_lo` = 0xFFFFFFFF and `rem_hi` = the dividend as given. In every other completion `zero_div` is 0, and `zero_div` is never 1 without `done`.
- R7: A `start` pulse while `busy` is 1 is ignored. The running operation finishes on time with its own results, and no further `done` follows.
- R8: `quo_lo` and `rem_hi` change only in the cycle `done` is 1, and hold their values between completions.
- R9: Signed 0x80000000 divided by 0xFFFFFFFF gives quotient 0x80000000 (two's complement wrap) and remainder 0.
- R10: `busy` is 0 in the cycle `done` is 1, so a new `start` may be accepted at the very next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| signed_mode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | 32 | Dividend, sampled on the accepting edge |
| divisor | input | 32 | Divisor, sampled on the accepting edge |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| zero_div | output | 1 | Divisor was zero; valid with `done` |
| quo_lo | output | 32 | Quotient |
| rem_hi | output | 32 | Remainder |

## Verification
Every result comes from the same fixed schedule. The accepting edge is followed by 32 step edges and one finishing edge, so `done`, `zero_div`, `quo_lo` and `rem_hi` all become valid after the 34th edge, counting the accepting edge as the first. The bench drives inputs on falling edges and counts falling edges from the accepting one. It requires `done` exactly at count 34, and it samples the results there and again several cycles later to check that they hold. A bound checker keeps its own cycle counter from the accepting edge and requires `done` to coincide with that same count. For a `start` sent mid-operation, the bench checks that completion still comes at count 34 with the first operands' results, and that no second `done` arrives.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_FIN  = 2'd2
  } div_state_t;

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         sgn,
  output logic [W-1:0] a_mag,
  output logic [W-1:0] b_mag,
  output logic         q_neg,
  output logic         r_neg,
  output logic         b_zero
);

  logic a_is_neg;
  logic b_is_neg;

  always_comb begin
    a_is_neg = sgn & a_in[W-1];
    b_is_neg = sgn & b_in[W-1];
    a_mag    = a_is_neg ? (~a_in + 1'b1) : a_in;
    b_mag    = b_is_neg ? (~b_in + 1'b1) : b_in;
    q_neg    = a_is_neg ^ b_is_neg;
    r_neg    = a_is_neg;
    b_zero   = (b_in == '0);
  end

endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int W = 32
) (
  input  logic [2*W:0] rem_in,
  input  logic [W-1:0] dvs,
  output logic [2*W:0] rem_out
);

  logic [W+1:0] trial;

  always_comb begin
    trial = {1'b0, rem_in[2*W:W]} - {2'b00, dvs};
    if (!trial[W+1]) begin
      // trial fits: keep difference, shift left, new quotient bit is 1
      rem_out = {trial[W-1:0], rem_in[W-1:0], 1'b1};
    end else begin
      // trial negative: keep old upper part, shift left, quotient bit 0
      rem_out = {rem_in[2*W-1:0], 1'b0};
    end
  end

endmodule

// File: rtl/div_result_fix.sv
module div_result_fix #(
  parameter int W = 32
) (
  input  logic [2*W:0] rem_in,
  input  logic         q_neg,
  input  logic         r_neg,
  input  logic         b_zero,
  input  logic [W-1:0] dvd_raw,
  output logic [W-1:0] q_out,
  output logic [W-1:0] r_out
);

  logic [W-1:0] q_mag;
  logic [W-1:0] r_mag;

  always_comb begin
    q_mag = rem_in[W-1:0];
    // one-bit right correction of the over-shifted remainder
    r_mag = rem_in[2*W:W+1];
    if (b_zero) begin
      q_out = '1;
      r_out = dvd_raw;
    end else begin
      q_out = q_neg ? (~q_mag + 1'b1) : q_mag;
      r_out = r_neg ? (~r_mag + 1'b1) : r_mag;
    end
  end

endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         signed_mode,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         zero_div,
  output logic [W-1:0] quo_lo,
  output logic [W-1:0] rem_hi
);

  localparam int CW   = (W > 1) ? $clog2(W) : 1;
  localparam int RW   = 2 * W + 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  div_state_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [RW-1:0] rem_q, rem_d, rem_step, rem_init;
  logic [W-1:0]  dvs_q, dvd_q;
  logic          qneg_q, rneg_q, bz_q;
  logic [W-1:0]  quo_q, quo_d, remo_q, remo_d;
  logic          done_q, done_d, zd_q, zd_d;

  logic [W-1:0]  a_mag, b_mag;
  logic          q_neg, r_neg, b_zero;
  logic [W-1:0]  fix_q, fix_r;

  logic          accept;
  logic          opnd_en;
  logic          rem_en;
  logic          cnt_en;
  logic          res_en;

  div_operand_prep #(.W(W)) prep_i (
    .a_in   (dividend),
    .b_in   (divisor),
    .sgn    (signed_mode),
    .a_mag  (a_mag),
    .b_mag  (b_mag),
    .q_neg  (q_neg),
    .r_neg  (r_neg),
    .b_zero (b_zero)
  );

  div_step #(.W(W)) step_i (
    .rem_in  (rem_q),
    .dvs     (dvs_q),
    .rem_out (rem_step)
  );

  div_result_fix #(.W(W)) fix_i (
    .rem_in  (rem_q),
    .q_neg   (qneg_q),
    .r_neg   (rneg_q),
    .b_zero  (bz_q),
    .dvd_raw (dvd_q),
    .q_out   (fix_q),
    .r_out   (fix_r)
  );

  // initial load: dividend right-justified, then the first left shift
  assign rem_init = {{W{1'b0}}, a_mag, 1'b0};

  // next-state logic
  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    rem_d   = rem_q;
    quo_d   = quo_q;
    remo_d  = remo_q;
    done_d  = 1'b0;
    zd_d    = 1'b0;
    accept  = 1'b0;
    opnd_en = 1'b0;
    rem_en  = 1'b0;
    cnt_en  = 1'b0;
    res_en  = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          accept  = 1'b1;
          opnd_en = 1'b1;
          rem_en  = 1'b1;
          cnt_en  = 1'b1;
          rem_d   = rem_init;
          cnt_d   = '0;
          st_d    = S_RUN;
        end
      end
      S_RUN: begin
        rem_en = 1'b1;
        cnt_en = 1'b1;
        rem_d  = rem_step;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          st_d = S_FIN;
        end
      end
      S_FIN: begin
        res_en = 1'b1;
        quo_d  = fix_q;
        remo_d = fix_r;
        done_d = 1'b1;
        zd_d   = bz_q;
        st_d   = S_IDLE;
      end
      default: begin
        st_d = S_IDLE;
      end
    endcase
  end

  // state and counter registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  // datapath registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      dvs_q  <= '0;
      dvd_q  <= '0;
      qneg_q <= 1'b0;
      rneg_q <= 1'b0;
      bz_q   <= 1'b0;
    end else begin
      if (rem_en) begin
        rem_q <= rem_d;
      end
      if (opnd_en) begin
        dvs_q  <= b_mag;
        dvd_q  <= dividend;
        qneg_q <= q_neg;
        rneg_q <= r_neg;
        bz_q   <= b_zero;
      end
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      remo_q <= '0;
      done_q <= 1'b0;
      zd_q   <= 1'b0;
    end else begin
      done_q <= done_d;
      zd_q   <= zd_d;
      if (res_en) begin
        quo_q  <= quo_d;
        remo_q <= remo_d;
      end
    end
  end

  assign busy     = (st_q != S_IDLE);
  assign done     = done_q;
  assign zero_div = zd_q;
  assign quo_lo   = quo_q;
  assign rem_hi   = remo_q;

endmodule

// File: rtl/seq_divider_chk.sv
module seq_divider_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         zero_div,
  input logic [W-1:0] quo_lo,
  input logic [W-1:0] rem_hi
);

  localparam int LW = $clog2(W + 8) + 1;
  localparam logic [LW-1:0] DUE = LW'(W + 2);

  logic [LW-1:0] lat_q;

  // cycles since the accepting edge, counted independently of the design
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (start && !busy) begin
      lat_q <= LW'(1);
    end else if (busy) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == DUE));

  p_flag_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    zero_div |-> done);

  p_zero_quot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && zero_div) |-> (quo_lo == {W{1'b1}}));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(quo_lo) || done));

  p_hold_rem_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(rem_hi) || done));

  p_idle_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind seq_divider seq_divider_chk #(.W(W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .zero_div (zero_div),
  .quo_lo   (quo_lo),
  .rem_hi   (rem_hi)
);

// File: tb/seq_divider_tb_top.sv
`timescale 1ns/1ps
module seq_divider_tb_top;

  localparam int NV = 12;
  // each entry: {signed_mode, dividend, divisor}
  localparam logic [64:0] VEC [NV] = '{
    {1'b0, 32'd100,        32'd7},
    {1'b0, 32'hFFFF_FFFF,  32'd1},
    {1'b0, 32'hFFFF_FFFF,  32'hFFFF_FFFF},
    {1'b0, 32'd5,          32'd9},
    {1'b0, 32'h8000_0000,  32'h8000_0001},
    {1'b0, 32'hDEAD_BEEF,  32'h0000_1234},
    {1'b1, 32'hFFFF_FFF9,  32'd2},
    {1'b1, 32'd7,          32'hFFFF_FFFE},
    {1'b1, 32'hFFFF_FFF9,  32'hFFFF_FFFE},
    {1'b1, 32'h8000_0000,  32'hFFFF_FFFF},
    {1'b1, 32'h1234_5678,  32'hFFFF_FFFF},
    {1'b1, 32'd0,          32'hFFFF_FFFB}
  };

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        signed_mode;
  logic [31:0] dividend;
  logic [31:0] divisor;
  logic        busy;
  logic        done;
  logic        zero_div;
  logic [31:0] quo_lo;
  logic [31:0] rem_hi;

  int n_run;
  int n_fail;

  seq_divider #(.W(32)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .signed_mode (signed_mode),
    .dividend    (dividend),
    .divisor     (divisor),
    .busy        (busy),
    .done        (done),
    .zero_div    (zero_div),
    .quo_lo      (quo_lo),
    .rem_hi      (rem_hi)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference results computed from the requirements
  task automatic ref_div(input logic sgn, input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] q, output logic [31:0] r);
    if (b == 32'd0) begin
      q = 32'hFFFF_FFFF;
      r = a;
    end else if (!sgn) begin
      q = a / b;
      r = a % b;
    end else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
      q = 32'h8000_0000;
      r = 32'd0;
    end else begin
      q = $signed(a) / $signed(b);
      r = $signed(a) % $signed(b);
    end
  endtask

  // run one operation; lat counts falling edges after the accepting edge
  task automatic run_op(input logic sgn, input logic [31:0] a, input logic [31:0] b,
                        input bit intrude, output int lat,
                        output logic [31:0] q, output logic [31:0] r, output logic dz);
    @(negedge clk);
    start = 1'b1;
    signed_mode = sgn;
    dividend = a;
    divisor = b;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
      if (intrude && lat == 5) begin
        start = 1'b1;
        signed_mode = ~sgn;
        dividend = 32'h0000_0003;
        divisor = 32'h0000_0000;
      end
      if (intrude && lat == 6) begin
        start = 1'b0;
      end
    end
    q = quo_lo;
    r = rem_hi;
    dz = zero_div;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lat;
    logic [31:0] q, r, eq, er;
    logic dz;
    n_run = 0;
    n_fail = 0;
    rst_n = 1'b0;
    start = 1'b0;
    signed_mode = 1'b0;
    dividend = '0;
    divisor = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 quo", quo_lo, 32'd0);
    chk("R1 rem", rem_hi, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {30'd0, busy, zero_div}, 32'd0);

    // table walk: R2 latency, R3 unsigned, R4/R5 signed, R9 overflow case
    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][64], VEC[i][63:32], VEC[i][31:0], 1'b0, lat, q, r, dz);
      ref_div(VEC[i][64], VEC[i][63:32], VEC[i][31:0], eq, er);
      chk("R2 latency", lat, 32'd34);
      chk(VEC[i][64] ? "R4 quotient" : "R3 quotient", q, eq);
      chk(VEC[i][64] ? "R5 remainder" : "R3 remainder", r, er);
      chk("R6 no flag", {31'd0, dz}, 32'd0);
      chk("R10 idle at done", {31'd0, busy}, 32'd0);
      if (i == 9) begin
        chk("R9 quotient", q, 32'h8000_0000);
        chk("R9 remainder", r, 32'd0);
      end
    end

    // R6 divide by zero, both modes
    run_op(1'b0, 32'h0000_1234, 32'd0, 1'b0, lat, q, r, dz);
    chk("R6 flag unsigned", {31'd0, dz}, 32'd1);
    chk("R6 quotient", q, 32'hFFFF_FFFF);
    chk("R6 remainder", r, 32'h0000_1234);
    chk("R6 latency", lat, 32'd34);
    run_op(1'b1, 32'hFFFF_FFFB, 32'd0, 1'b0, lat, q, r, dz);
    chk("R6 flag signed", {31'd0, dz}, 32'd1);
    chk("R6 signed remainder", r, 32'hFFFF_FFFB);
    @(negedge clk);
    chk("R6 flag drops", {31'd0, zero_div}, 32'd0);

    // R7 start while busy ignored
    run_op(1'b0, 32'd1000, 32'd33, 1'b1, lat, q, r, dz);
    chk("R7 latency", lat, 32'd34);
    chk("R7 quotient", q, 32'd30);
    chk("R7 remainder", r, 32'd10);
    chk("R7 flag", {31'd0, dz}, 32'd0);
    lat = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (done || busy) lat++;
    end
    chk("R7 no second op", lat, 32'd0);
    // R8 results hold
    chk("R8 quotient held", quo_lo, 32'd30);
    chk("R8 remainder held", rem_hi, 32'd10);

    // R1 reset mid-operation
    @(negedge clk);
    start = 1'b1;
    dividend = 32'd77;
    divisor = 32'd5;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 mid-op busy", {31'd0, busy}, 32'd0);
    chk("R1 mid-op quo", quo_lo, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk("R1 no late done", {30'd0, done, busy}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule